// File: doc/BRIEF.md
# SAR ADC Conversion Sequencer

This block is the digital half of an 8-bit successive-approximation converter with four analog inputs. Software writes one control byte that picks the input, the conversion-clock divider and whether conversions repeat. The block divides the system clock down to a conversion clock and drives the analog multiplexer select and the sample-and-hold enable. It then presents trial codes to the DAC and reads the comparator answer, one bit per conversion clock, starting with the most significant bit.

When a conversion ends, the search result goes into a read-only data register and a complete flag is raised in the control byte. An interrupt flag is also set. Its request leaves the block only while the interrupt enable input is high, and it stays until acknowledged. In continuous mode the next conversion starts on the cycle after one ends. A write to the control byte always starts a fresh conversion and abandons any conversion in progress.

Top module: `sar_adc_seq`

## Requirements
- R1: During and right after synchronous reset, `ctl_rdata` and `data_rdata` read 00h, and `irq`, `sample_en` and `ch_sel` are 0.
- R2: A control write stores bit 6 as the continuous flag, bits [5:4] as the divider select and bits [3:2] as the channel. `ctl_rdata` returns these fields in the same positions, with the complete flag in bit 7 and bits [1:0] reading 0.
- R3: With divider select s, one conversion clock lasts 8·2^s system cycles. A conversion ends exactly 20 conversion clocks after the clock edge that took the control write.
- R4: `sample_en` is high for the first 4 conversion clocks of every conversion and low at all other times.
- R5: The result equals the input code found by an MSB-first binary search against `cmp_in` (1 when the input is at or above `dac_code`). An input at or above full scale gives FFh and one at or below zero gives 00h.
- R6: At the end of a conversion, `data_rdata` takes the result and the complete flag (bit 7) is set in the same cycle. `data_rdata` changes at no other time.
- R7: The complete flag is cleared by any control write or by a `data_rd` strobe. When a data read coincides with the end of a conversion, the flag ends up set.
- R8: With the continuous flag 0, the block goes idle after one conversion. With it 1, a new conversion starts immediately after each one ends.
- R9: A control write during a conversion abandons that conversion without updating the data register or the flags, and restarts with the new settings.
- R10: Each completed conversion sets an interrupt flag, and `irq` is that flag ANDed with `irq_en`. The flag is cleared by `irq_ack`, except that a coincident completion keeps it set.
- R11: `ch_sel` carries the channel field of the control register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control write data |
| ctl_rdata | output | 8 | Control/status register read value |
| data_rd | input | 1 | Data register read strobe (clears complete flag) |
| data_rdata | output | 8 | Conversion result register |
| irq_en | input | 1 | Interrupt enable |
| irq_ack | input | 1 | Interrupt acknowledge |
| irq | output | 1 | Gated interrupt request |
| ch_sel | output | 2 | Analog multiplexer select |
| sample_en | output | 1 | Sample-and-hold enable |
| dac_code | output | 8 | Trial code for the DAC |
| cmp_in | input | 1 | Comparator result, 1 when input >= DAC |

## Verification
Several relations are checked on every cycle: how the complete flag responds to writes, reads and conversion ends; the rule that the data register changes only at a conversion end; the effect of acknowledge on the request; and sampling starting right after a write. The bench's scenarios are needed for the rest. These are the exact conversion length for each divider, the saturating search results on each channel, coincident read and acknowledge at the completion edge, back-to-back continuous conversions, and an abort part-way through a conversion.

// File: rtl/sar_adc_seq_pkg.sv
`timescale 1ns/1ps
package sar_adc_seq_pkg;
    localparam int REG_W         = 8;
    localparam int RES_W         = 8;
    localparam int CH_W          = 2;
    localparam int DSEL_W        = 2;
    localparam int DIV_BASE_LOG2 = 3;
    localparam int SAMPLE_TICKS  = 4;
    localparam int SETTLE_TICKS  = 8;

    localparam int CTL_DONE_BIT  = 7;
    localparam int CTL_CONT_BIT  = 6;
    localparam int CTL_DSEL_LSB  = 4;
    localparam int CTL_CHAN_LSB  = 2;

    typedef struct packed {
        logic              cont;
        logic [DSEL_W-1:0] dsel;
        logic [CH_W-1:0]   chan;
    } ctl_t;

    typedef enum logic [1:0] {
        ST_SAMPLE = 2'd0,
        ST_DECIDE = 2'd1,
        ST_SETTLE = 2'd2
    } stage_e;

    function automatic ctl_t unpack_ctl(input logic [REG_W-1:0] b);
        ctl_t c;
        c.cont = b[CTL_CONT_BIT];
        c.dsel = b[CTL_DSEL_LSB +: DSEL_W];
        c.chan = b[CTL_CHAN_LSB +: CH_W];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] pack_ctl(input logic done, input ctl_t c);
        logic [REG_W-1:0] b;
        b = '0;
        b[CTL_DONE_BIT]              = done;
        b[CTL_CONT_BIT]              = c.cont;
        b[CTL_DSEL_LSB +: DSEL_W]    = c.dsel;
        b[CTL_CHAN_LSB +: CH_W]      = c.chan;
        return b;
    endfunction
endpackage

// File: rtl/sar_adc_seq_clkdiv.sv
`timescale 1ns/1ps
module sar_adc_seq_clkdiv #(
    parameter int DSEL_W    = sar_adc_seq_pkg::DSEL_W,
    parameter int BASE_LOG2 = sar_adc_seq_pkg::DIV_BASE_LOG2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              restart,
    input  logic [DSEL_W-1:0] dsel,
    output logic              tick
);
    localparam int CNT_W = BASE_LOG2 + (1 << DSEL_W) - 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;

    // Divide by 2^(BASE_LOG2 + dsel): the tick fires on the last count.
    assign limit = CNT_W'((1 << (BASE_LOG2 + int'(dsel))) - 1);
    assign tick  = run && !restart && (cnt == limit);

    always_ff @(posedge clk) begin
        if (rst || restart || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/sar_adc_seq_core.sv
`timescale 1ns/1ps
module sar_adc_seq_core
    import sar_adc_seq_pkg::*;
#(
    parameter int RES_W_P   = RES_W,
    parameter int SAMPLE_P  = SAMPLE_TICKS,
    parameter int SETTLE_P  = SETTLE_TICKS
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               cont,
    input  logic               tick,
    input  logic               cmp_in,
    output logic               busy,
    output logic               sample_en,
    output logic [RES_W_P-1:0] dac_code,
    output logic               done,
    output logic [RES_W_P-1:0] result
);
    localparam int TOTAL   = SAMPLE_P + RES_W_P + SETTLE_P;
    localparam int DEC_END = SAMPLE_P + RES_W_P;
    localparam int PH_W    = $clog2(TOTAL);
    localparam int IDX_W   = (RES_W_P > 1) ? $clog2(RES_W_P) : 1;

    logic [PH_W-1:0]    phase;
    logic [RES_W_P-1:0] sar;
    logic [RES_W_P-1:0] trial;
    logic [IDX_W-1:0]   bit_idx;
    logic               last;
    stage_e             stage;

    always_comb begin
        if (phase < PH_W'(SAMPLE_P)) begin
            stage = ST_SAMPLE;
        end else if (phase < PH_W'(DEC_END)) begin
            stage = ST_DECIDE;
        end else begin
            stage = ST_SETTLE;
        end
    end

    // Decision phases walk from the MSB down to bit 0.
    assign bit_idx   = IDX_W'(DEC_END - 1 - int'(phase));
    assign trial     = (stage == ST_DECIDE) ? (RES_W_P'(1) << bit_idx) : '0;
    assign dac_code  = sar | trial;
    assign last      = (phase == PH_W'(TOTAL - 1));
    assign done      = busy && tick && last && !start;
    assign sample_en = busy && (stage == ST_SAMPLE);
    assign result    = sar;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            phase <= '0;
            sar   <= '0;
        end else if (start) begin
            busy  <= 1'b1;
            phase <= '0;
            sar   <= '0;
        end else if (tick) begin
            if (last) begin
                phase <= '0;
                sar   <= '0;
                busy  <= cont;
            end else begin
                phase <= phase + PH_W'(1);
                if (stage == ST_DECIDE && cmp_in) begin
                    sar <= sar | trial;
                end
            end
        end
    end
endmodule

// File: rtl/sar_adc_seq_regs.sv
`timescale 1ns/1ps
module sar_adc_seq_regs
    import sar_adc_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    input  logic             data_rd,
    input  logic             irq_en,
    input  logic             irq_ack,
    input  logic             conv_done,
    input  logic [RES_W-1:0] result,
    output ctl_t             ctl,
    output logic [REG_W-1:0] ctl_rdata,
    output logic [RES_W-1:0] data_rdata,
    output logic             irq
);
    logic done_flag;
    logic irq_flag;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl        <= '0;
            data_rdata <= '0;
            done_flag  <= 1'b0;
            irq_flag   <= 1'b0;
        end else begin
            if (reg_wr) begin
                ctl <= unpack_ctl(reg_wdata);
            end
            if (conv_done) begin
                data_rdata <= result;
            end
            // A finishing conversion outranks a coincident clear.
            if (conv_done) begin
                done_flag <= 1'b1;
            end else if (reg_wr || data_rd) begin
                done_flag <= 1'b0;
            end
            if (conv_done) begin
                irq_flag <= 1'b1;
            end else if (irq_ack) begin
                irq_flag <= 1'b0;
            end
        end
    end

    assign ctl_rdata = pack_ctl(done_flag, ctl);
    assign irq       = irq_flag && irq_en;
endmodule

// File: rtl/sar_adc_seq.sv
`timescale 1ns/1ps
module sar_adc_seq
    import sar_adc_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] ctl_rdata,
    input  logic             data_rd,
    output logic [RES_W-1:0] data_rdata,
    input  logic             irq_en,
    input  logic             irq_ack,
    output logic             irq,
    output logic [CH_W-1:0]  ch_sel,
    output logic             sample_en,
    output logic [RES_W-1:0] dac_code,
    input  logic             cmp_in
);
    ctl_t             ctl;
    logic             busy;
    logic             conv_tick;
    logic             conv_done;
    logic [RES_W-1:0] result;

    sar_adc_seq_clkdiv u_div (
        .clk     (clk),
        .rst     (rst),
        .run     (busy),
        .restart (reg_wr),
        .dsel    (ctl.dsel),
        .tick    (conv_tick)
    );

    sar_adc_seq_core u_core (
        .clk       (clk),
        .rst       (rst),
        .start     (reg_wr),
        .cont      (ctl.cont),
        .tick      (conv_tick),
        .cmp_in    (cmp_in),
        .busy      (busy),
        .sample_en (sample_en),
        .dac_code  (dac_code),
        .done      (conv_done),
        .result    (result)
    );

    sar_adc_seq_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .reg_wr     (reg_wr),
        .reg_wdata  (reg_wdata),
        .data_rd    (data_rd),
        .irq_en     (irq_en),
        .irq_ack    (irq_ack),
        .conv_done  (conv_done),
        .result     (result),
        .ctl        (ctl),
        .ctl_rdata  (ctl_rdata),
        .data_rdata (data_rdata),
        .irq        (irq)
    );

    assign ch_sel = ctl.chan;
endmodule

// File: rtl/sar_adc_seq_chk.sv
`timescale 1ns/1ps
module sar_adc_seq_chk #(
    parameter int RES_W = sar_adc_seq_pkg::RES_W
) (
    input logic             clk,
    input logic             rst,
    input logic             reg_wr,
    input logic             data_rd,
    input logic             irq_ack,
    input logic             conv_done,
    input logic             done_bit,
    input logic [RES_W-1:0] data_rdata,
    input logic             irq,
    input logic             sample_en
);
    logic past_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            past_ok <= 1'b0;
        end else begin
            past_ok <= 1'b1;
        end
    end

    AST_WR_CLEARS_DONE: assert property (@(posedge clk) disable iff (rst)
        reg_wr |=> !done_bit); // R7

    AST_RD_CLEARS_DONE: assert property (@(posedge clk) disable iff (rst)
        (data_rd && !conv_done) |=> !done_bit); // R7

    AST_END_SETS_DONE: assert property (@(posedge clk) disable iff (rst)
        conv_done |=> done_bit); // R6

    AST_DATA_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !$past(conv_done)) |-> $stable(data_rdata)); // R6

    AST_ACK_DROPS_IRQ: assert property (@(posedge clk) disable iff (rst)
        (irq_ack && !conv_done) |=> !irq); // R10

    AST_WR_STARTS_SAMPLE: assert property (@(posedge clk) disable iff (rst)
        reg_wr |=> sample_en); // R4
endmodule

bind sar_adc_seq sar_adc_seq_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .reg_wr     (reg_wr),
    .data_rd    (data_rd),
    .irq_ack    (irq_ack),
    .conv_done  (conv_done),
    .done_bit   (ctl_rdata[7]),
    .data_rdata (data_rdata),
    .irq        (irq),
    .sample_en  (sample_en)
);

// File: tb/test_sar_adc_seq.sv
`timescale 1ns/1ps
module test_sar_adc_seq;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] ctl_rdata;
    logic       data_rd = 1'b0;
    logic [7:0] data_rdata;
    logic       irq_en = 1'b0;
    logic       irq_ack = 1'b0;
    logic       irq;
    logic [1:0] ch_sel;
    logic       sample_en;
    logic [7:0] dac_code;
    logic       cmp_in;

    int vin [4];
    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    // Ideal comparator: input code at or above the trial code.
    assign cmp_in = (vin[ch_sel] >= int'(dac_code));

    sar_adc_seq i_sar_adc_seq (
        .clk        (clk),
        .rst        (rst),
        .reg_wr     (reg_wr),
        .reg_wdata  (reg_wdata),
        .ctl_rdata  (ctl_rdata),
        .data_rd    (data_rd),
        .data_rdata (data_rdata),
        .irq_en     (irq_en),
        .irq_ack    (irq_ack),
        .irq        (irq),
        .ch_sel     (ch_sel),
        .sample_en  (sample_en),
        .dac_code   (dac_code),
        .cmp_in     (cmp_in)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    endtask

    function automatic int clip(input int v);
        if (v > 255) return 255;
        if (v < 0) return 0;
        return v;
    endfunction

    function automatic logic [7:0] mk(input int cont, input int sel, input int ch);
        return 8'((cont << 6) | (sel << 4) | (ch << 2));
    endfunction

    // Behavioural reference: elapsed system cycles since the start of a conversion.
    int m_busy, m_cnt, m_cont, m_sel, m_ch, m_done, m_iflag, m_data;
    always @(posedge clk) begin
        int fin;
        fin = 0;
        if (rst) begin
            m_busy = 0; m_cnt = 0; m_cont = 0; m_sel = 0; m_ch = 0;
            m_done = 0; m_iflag = 0; m_data = 0;
        end else begin
            if (reg_wr) begin
                m_cont = int'(reg_wdata[6]);
                m_sel  = int'(reg_wdata[5:4]);
                m_ch   = int'(reg_wdata[3:2]);
                m_done = 0; m_busy = 1; m_cnt = 0;
            end else if (m_busy != 0) begin
                m_cnt++;
                if (m_cnt == 20 * (8 << m_sel)) begin
                    fin = 1;
                    m_data = clip(vin[m_ch]);
                    m_cnt = 0;
                    m_busy = m_cont;
                end
            end
            if (fin != 0) begin
                m_done = 1; m_iflag = 1;
            end else begin
                if (data_rd) m_done = 0;
                if (irq_ack) m_iflag = 0;
            end
        end
        #1;
        check("R2/R7", "ctl_rdata", int'(ctl_rdata),
              (m_done << 7) | (m_cont << 6) | (m_sel << 4) | (m_ch << 2));
        check("R5/R6", "data_rdata", int'(data_rdata), m_data);
        check("R4", "sample_en", int'(sample_en),
              (m_busy != 0 && m_cnt < 4 * (8 << m_sel)) ? 1 : 0);
        check("R10", "irq", int'(irq), (m_iflag != 0 && irq_en) ? 1 : 0);
        check("R11", "ch_sel", int'(ch_sel), m_ch);
    end

    task automatic wr(input logic [7:0] v);
        reg_wr = 1'b1; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd();
        data_rd = 1'b1;
        @(negedge clk);
        data_rd = 1'b0;
    endtask

    task automatic ack();
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    task automatic wait_done(output int k, input int k0);
        k = k0;
        while (ctl_rdata[7] == 1'b0) begin
            @(negedge clk);
            k++;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_errors++;
        $display("FAIL R3 watchdog: actual no completion expected completion");
        finish_run();
    end

    initial begin
        int k;
        vin[0] = 100; vin[1] = 300; vin[2] = -5; vin[3] = 90;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", "ctl_rdata reset", int'(ctl_rdata), 0);
        check("R1", "data reset", int'(data_rdata), 0);
        check("R1", "sample_en reset", int'(sample_en), 0);
        check("R1", "irq reset", int'(irq), 0);
        rst = 1'b0;
        @(negedge clk);

        // single conversion, channel 0, divide by 8
        wr(mk(0, 0, 0));
        check("R4", "sampling after write", int'(sample_en), 1);
        repeat (32) @(negedge clk);
        check("R4", "sampling ends after 4 ticks", int'(sample_en), 0);
        wait_done(k, 32);
        check("R3", "cycles at divide 8", k, 160);
        check("R5", "mid-scale result", int'(data_rdata), 100);
        check("R2", "readback after done", int'(ctl_rdata), 8'h80);
        rd();
        check("R7", "read clears complete", int'(ctl_rdata[7]), 0);
        repeat (200) @(negedge clk);
        check("R8", "single mode idle", int'(sample_en), 0);

        // channel 1 saturates high, divide by 16
        wr(mk(0, 1, 1));
        check("R11", "channel select 1", int'(ch_sel), 1);
        wait_done(k, 0);
        check("R3", "cycles at divide 16", k, 320);
        check("R5", "full-scale saturation", int'(data_rdata), 8'hFF);
        check("R2", "readback fields", int'(ctl_rdata), 8'h94);

        // channel 2 below zero
        wr(mk(0, 0, 2));
        check("R7", "write clears complete", int'(ctl_rdata[7]), 0);
        wait_done(k, 0);
        check("R5", "zero saturation", int'(data_rdata), 0);

        // interrupt gating and acknowledge
        irq_en = 1'b1;
        @(negedge clk);
        check("R10", "pending flag gated through", int'(irq), 1);
        ack();
        check("R10", "ack clears request", int'(irq), 0);
        wr(mk(0, 2, 3));
        wait_done(k, 0);
        check("R3", "cycles at divide 32", k, 640);
        check("R10", "completion raises irq", int'(irq), 1);
        check("R5", "channel 3 result", int'(data_rdata), 90);
        irq_en = 1'b0;
        @(negedge clk);
        check("R10", "enable low masks irq", int'(irq), 0);
        irq_en = 1'b1;
        ack();

        // read and acknowledge landing on the completion edge
        wr(mk(0, 0, 0));
        repeat (159) @(negedge clk);
        data_rd = 1'b1; irq_ack = 1'b1;
        @(negedge clk);
        data_rd = 1'b0; irq_ack = 1'b0;
        check("R7", "completion beats read", int'(ctl_rdata[7]), 1);
        check("R10", "completion beats ack", int'(irq), 1);
        ack();

        // continuous mode, then abort into single mode
        wr(mk(1, 0, 3));
        check("R2", "continuous readback", int'(ctl_rdata), 8'h4C);
        wait_done(k, 0);
        check("R8", "first continuous result", int'(data_rdata), 90);
        rd();
        wait_done(k, 1);
        check("R8", "back-to-back conversion", k, 160);
        repeat (50) @(negedge clk);
        wr(mk(0, 0, 1));
        wait_done(k, 0);
        check("R9", "abort restarts count", k, 160);
        check("R9", "new channel after abort", int'(data_rdata), 8'hFF);
        repeat (200) @(negedge clk);
        check("R8", "idle after single", int'(sample_en), 0);

        // slowest divider
        vin[0] = 200;
        wr(mk(0, 3, 0));
        wait_done(k, 0);
        check("R3", "cycles at divide 64", k, 1280);
        check("R5", "result at divide 64", int'(data_rdata), 200);

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule